// File: doc/BRIEF.md
# Non-Volatile Write Sequencer

This block sits between a serial register-access decoder and a small register file whose first few entries each have a persistent shadow copy. Every decoded data byte is written straight into volatile storage. When the persist-select bit of the control register is set and the byte targets one of the shadowed registers, the block also keeps the address and data as a pending commit. A commit is started only when the chip select goes inactive, and only for the last eligible byte of that transaction.

Once a commit starts, the block issues a one-cycle program request carrying the pending address and data. It then holds a work-in-progress flag for a programming interval set by a parameter in system clock cycles. The flag is merged into bit 5 of the control register read-back value. While the flag is high, commit candidates are dropped, and volatile writes go on as normal. The persistent cells are outside the block; the timer stands in for their programming time.

Top module: `nv_write_sequencer`

## Requirements
- R1: A cycle with `wr_stb` high gives `vol_we` high in the next cycle, with `vol_addr`/`vol_data` equal to the sampled address and data, whatever the persist-select bit holds. `vol_we` is low in every other cycle.
- R2: A write becomes a commit candidate only when `ctrl_reg[7]` is 1 and the address is below `NV_REGS` (default 4, so addresses 0 to 3). Any other write never leads to `nv_req`.
- R3: `nv_req` never rises on the data byte. It pulses for one cycle, in the cycle after a sampled `cs_rise`, and only if a candidate is pending and `wip` is low.
- R4: When one transaction holds several candidates, the commit carries the address and data of the last candidate. `nv_addr`/`nv_data` are valid while `nv_req` is high.
- R5: `wip` rises together with `nv_req` and stays high for exactly `PROG_CYCLES`+1 cycles. It clears one cycle after the programming timer expires.
- R6: While `wip` is high, candidate writes are not retained and `cs_rise` starts no commit. A candidate sampled during that time is never committed later, including at a later `cs_rise` after `wip` has fallen.
- R7: `ctrl_rd` equals `ctrl_reg` with bit 5 replaced by `wip`.
- R8: After reset, `wip`, `nv_req` and `vol_we` are 0, and no candidate is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Decoded data byte strobe, one cycle |
| wr_addr | input | AW (4) | Register address of the byte |
| wr_data | input | DW (8) | Data byte |
| cs_rise | input | 1 | One-cycle pulse marking chip select going inactive |
| ctrl_reg | input | DW (8) | Current control register value; bit 7 selects persistent writes |
| vol_we | output | 1 | Volatile register write enable |
| vol_addr | output | AW (4) | Volatile write address |
| vol_data | output | DW (8) | Volatile write data |
| nv_req | output | 1 | One-cycle persistent program request |
| nv_addr | output | AW (4) | Address to program |
| nv_data | output | DW (8) | Data to program |
| wip | output | 1 | Programming in progress |
| ctrl_rd | output | DW (8) | Control register read-back with the progress flag in bit 5 |

## Verification
The properties assume that `wr_stb` and `cs_rise` are never high in the same cycle, and that `cs_rise` is a single-cycle pulse. The decoder cannot produce either overlap, because a data byte and the end of select are separate serial events. The stimulus drives each input for one whole cycle from the falling clock edge and leaves at least one idle cycle between a write and the select-release pulse. Writes and releases that fall inside the busy window are timed on purpose, so the drop paths are covered.

// File: rtl/nvws_pkg.sv
package nvws_pkg;
  // Bit positions inside the control register that neighbours decode.
  localparam int SEL_BIT = 7;  // persist select
  localparam int WIP_BIT = 5;  // read-only progress flag

  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_RUN  = 2'd1,
    TMR_DONE = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/nvws_vol_path.sv
module nvws_vol_path #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          vol_we,
  output logic [AW-1:0] vol_addr,
  output logic [DW-1:0] vol_data
);
  // Every decoded byte goes to volatile storage, one register stage later.
  always_ff @(posedge clk) begin
    if (rst) begin
      vol_we   <= 1'b0;
      vol_addr <= '0;
      vol_data <= '0;
    end else begin
      vol_we <= wr_stb;
      if (wr_stb) begin
        vol_addr <= wr_addr;
        vol_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/nvws_pending.sv
module nvws_pending #(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int NV_REGS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          persist_sel,
  input  logic          busy,
  input  logic          cs_rise,
  output logic          start,
  output logic [AW-1:0] pend_addr,
  output logic [DW-1:0] pend_data
);
  localparam logic [AW-1:0] NV_LIMIT = AW'(NV_REGS);

  logic pend_vld;
  logic eligible;

  assign eligible = wr_stb && persist_sel && (wr_addr < NV_LIMIT) && !busy;
  assign start    = cs_rise && pend_vld && !busy;

  // Newest eligible byte overwrites older ones; the release of select
  // always empties the slot, whether or not a commit could start.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (cs_rise) begin
      pend_vld <= 1'b0;
    end else if (eligible) begin
      pend_vld  <= 1'b1;
      pend_addr <= wr_addr;
      pend_data <= wr_data;
    end
  end
endmodule

// File: rtl/nvws_prog_timer.sv
module nvws_prog_timer
  import nvws_pkg::*;
#(
  parameter int PROG_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic wip
);
  localparam int CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  tmr_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TMR_IDLE;
      cnt   <= '0;
      wip   <= 1'b0;
    end else begin
      unique case (state)
        TMR_IDLE: if (start) begin
          state <= TMR_RUN;
          cnt   <= LOAD;
          wip   <= 1'b1;
        end
        TMR_RUN: begin
          if (cnt == '0) state <= TMR_DONE;  // timer expired
          else           cnt   <= cnt - 1'b1;
        end
        TMR_DONE: begin  // flag drops one cycle after expiry
          state <= TMR_IDLE;
          wip   <= 1'b0;
        end
        default: state <= TMR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nv_write_sequencer.sv
module nv_write_sequencer
  import nvws_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int NV_REGS     = 4,
  parameter int PROG_CYCLES = 2_500_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cs_rise,
  input  logic [DW-1:0] ctrl_reg,
  output logic          vol_we,
  output logic [AW-1:0] vol_addr,
  output logic [DW-1:0] vol_data,
  output logic          nv_req,
  output logic [AW-1:0] nv_addr,
  output logic [DW-1:0] nv_data,
  output logic          wip,
  output logic [DW-1:0] ctrl_rd
);
  logic          start;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  nvws_vol_path #(.AW(AW), .DW(DW)) u_vol (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .vol_we(vol_we), .vol_addr(vol_addr),
    .vol_data(vol_data)
  );

  nvws_pending #(.AW(AW), .DW(DW), .NV_REGS(NV_REGS)) u_pend (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .persist_sel(ctrl_reg[SEL_BIT]), .busy(wip),
    .cs_rise(cs_rise), .start(start), .pend_addr(pend_addr),
    .pend_data(pend_data)
  );

  nvws_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .wip(wip)
  );

  // Registered program request, aligned with the rise of wip.
  always_ff @(posedge clk) begin
    if (rst) begin
      nv_req  <= 1'b0;
      nv_addr <= '0;
      nv_data <= '0;
    end else begin
      nv_req <= start;
      if (start) begin
        nv_addr <= pend_addr;
        nv_data <= pend_data;
      end
    end
  end

  always_comb begin
    ctrl_rd          = ctrl_reg;
    ctrl_rd[WIP_BIT] = wip;
  end
endmodule

// File: rtl/nv_write_sequencer_chk.sv
module nv_write_sequencer_chk #(
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int NV_REGS     = 4,
  parameter int PROG_CYCLES = 2_500_000
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cs_rise,
  input logic          vol_we,
  input logic [AW-1:0] vol_addr,
  input logic [DW-1:0] vol_data,
  input logic          nv_req,
  input logic [AW-1:0] nv_addr,
  input logic          wip
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)      hi_cnt <= '0;
    else if (wip) hi_cnt <= hi_cnt + 1'b1;
    else          hi_cnt <= '0;
  end

  a_r1_vol_follows: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> vol_we && vol_addr == $past(wr_addr) && vol_data == $past(wr_data));

  a_r1_no_spurious_vol: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> !vol_we);

  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    nv_req |-> nv_addr < AW'(NV_REGS));

  a_r3_req_after_release: assert property (@(posedge clk) disable iff (rst)
    nv_req |-> $past(cs_rise));

  a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
    nv_req |=> !nv_req);

  a_r5_wip_rises_with_req: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> nv_req);

  a_r5_wip_length: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> hi_cnt == 32'(PROG_CYCLES + 1));

  a_r6_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    nv_req |-> !$past(wip));
endmodule

bind nv_write_sequencer nv_write_sequencer_chk #(
  .AW(AW), .DW(DW), .NV_REGS(NV_REGS), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .cs_rise(cs_rise), .vol_we(vol_we),
  .vol_addr(vol_addr), .vol_data(vol_data), .nv_req(nv_req),
  .nv_addr(nv_addr), .wip(wip)
);

// File: tb/nv_write_sequencer_tb_top.sv
module nv_write_sequencer_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NV_REGS = 4;
  localparam int P = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          cs_rise = 1'b0;
  logic [DW-1:0] ctrl_reg = '0;
  logic          vol_we, nv_req, wip;
  logic [AW-1:0] vol_addr, nv_addr;
  logic [DW-1:0] vol_data, nv_data, ctrl_rd;

  int n_cmp = 0;
  int n_bad = 0;
  bit wd_fired = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nv_write_sequencer #(.AW(AW), .DW(DW), .NV_REGS(NV_REGS), .PROG_CYCLES(P)) dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs_rise(cs_rise), .ctrl_reg(ctrl_reg), .vol_we(vol_we), .vol_addr(vol_addr),
    .vol_data(vol_data), .nv_req(nv_req), .nv_addr(nv_addr), .nv_data(nv_data),
    .wip(wip), .ctrl_rd(ctrl_rd)
  );

  // Scoreboard queues: {addr, data}
  logic [AW+DW-1:0] vol_q[$];
  logic [AW+DW-1:0] nv_q[$];

  // Reference model, advanced on the active edge from the requirements.
  bit               m_pend;
  logic [AW+DW-1:0] m_item;
  int               m_busy;  // cycles of wip still expected

  always @(posedge clk) begin
    if (rst) begin
      m_pend <= 1'b0;
      m_busy <= 0;
    end else begin
      if (m_busy > 0) m_busy <= m_busy - 1;
      if (wr_stb) vol_q.push_back({wr_addr, wr_data});
      if (cs_rise) begin
        m_pend <= 1'b0;
        if (m_pend && m_busy == 0) begin
          nv_q.push_back(m_item);
          m_busy <= P + 1;
        end
      end else if (wr_stb && ctrl_reg[7] && wr_addr < NV_REGS && m_busy == 0) begin
        m_pend <= 1'b1;
        m_item <= {wr_addr, wr_data};
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares outputs each cycle, away from the active edge.
  bit mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (vol_we) begin
        if (vol_q.size() == 0) check(1'b0, "R1", "unexpected vol_we", 32'(vol_addr), 0);
        else begin
          logic [AW+DW-1:0] e;
          e = vol_q.pop_front();
          check({vol_addr, vol_data} == e, "R1", "vol write", 32'({vol_addr, vol_data}), 32'(e));
        end
      end
      if (nv_req) begin
        if (nv_q.size() == 0)
          check(1'b0, "R2/R3/R6", "unexpected nv_req", 32'({nv_addr, nv_data}), 0);
        else begin
          logic [AW+DW-1:0] e;
          e = nv_q.pop_front();
          check({nv_addr, nv_data} == e, "R4", "committed item", 32'({nv_addr, nv_data}), 32'(e));
        end
      end
      check(wip == (m_busy != 0), "R5", "wip level", 32'(wip), 32'(m_busy != 0));
      check(ctrl_rd == {ctrl_reg[7:6], wip, ctrl_reg[4:0]}, "R7", "ctrl_rd",
            32'(ctrl_rd), 32'({ctrl_reg[7:6], wip, ctrl_reg[4:0]}));
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic release_cs();
    @(negedge clk);
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(wip == 1'b0 && nv_req == 1'b0 && vol_we == 1'b0, "R8", "reset outputs",
          32'({wip, nv_req, vol_we}), 0);
    mon_on = 1'b1;

    // R1 R2: persist select off, shadowed address -> volatile only
    ctrl_reg = 8'h00;
    wr(4'd1, 8'h3C); idle(2); release_cs(); idle(4);

    // R2: persist select on, address outside shadowed range
    ctrl_reg = 8'h80;
    wr(4'd5, 8'h77); idle(1); release_cs(); idle(4);

    // R3: candidate waits for the release of select
    wr(4'd2, 8'hA5); idle(6);
    check(nv_q.size() == 0 && !wip, "R3", "no commit before release", 32'(wip), 0);
    release_cs(); idle(P + 4);

    // R4: burst, last candidate wins, non-eligible tail ignored
    ctrl_reg = 8'h9F;
    wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd3, 8'h44); wr(4'd6, 8'h66);
    idle(1); release_cs(); idle(P + 4);

    // R6: candidates and releases during busy are dropped
    wr(4'd3, 8'hC3); idle(1); release_cs();
    idle(3);
    wr(4'd0, 8'hEE);              // volatile still written (R1)
    idle(1); release_cs();        // no commit (R6)
    idle(P + 4);
    release_cs(); idle(4);        // dropped candidate never returns (R6)

    // R7: read-back with select cleared and other bits set
    ctrl_reg = 8'h7F; idle(2);
    ctrl_reg = 8'hA0;
    wr(4'd2, 8'h5A); idle(1); release_cs(); idle(5);
    ctrl_reg = 8'h00; idle(P);

    check(vol_q.size() == 0, "R1", "vol queue drained", 32'(vol_q.size()), 0);
    check(nv_q.size() == 0, "R3/R4", "nv queue drained", 32'(nv_q.size()), 0);
    finish_run();
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    wd_fired = 1'b1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end
endmodule